// File: doc/BRIEF.md
# Paired-Channel Conversion Phase Offset Generator

Six converter channels sample together, but the start of each channel's filter accumulation window is shifted in time. The channels form three pairs. In each pair the odd channel is the reference and the even channel is offset from it by a signed count of decimation-clock ticks. A common frame strobe, qualified by the decimation-clock enable, starts every conversion frame. For each channel the block emits an accumulation-start pulse when that channel's window opens. It emits a data-ready pulse one full frame later.

A negative count is realised by holding back the reference channel instead of moving the even channel ahead. Every per-channel offset is therefore a non-negative tick count measured from the frame tick. The signed offset word is captured only at a frame tick, so a frame in progress always keeps the offsets it started with. Frame strobes are expected at least `FRAME_TICKS` ticks apart, with `FRAME_TICKS` larger than the largest magnitude (128). Because of that, each channel can have two data-ready windows pending at once, and both are honoured.

Top module: `phx_phase_delay_gen`

## Requirements
- R1: While `rst` is sampled high, `accStart` and `dataReady` are all zero from the next cycle on, and frame strobes are ignored. Offsets pending from a frame begun before reset produce no pulse after `rst` is released.
- R2: `phaseCode[7:0]` controls the pair of channels 0 and 1, `phaseCode[15:8]` controls channels 2 and 3, and `phaseCode[23:16]` controls channels 4 and 5. Each byte is an 8-bit two's-complement count c in the range -128 to +127.
- R3: For c > 0 the odd channel of the pair opens at tick 0 and the even channel opens at tick c.
- R4: For c < 0 the even channel opens at tick 0 and the odd channel opens at tick |c|. This holds for c = -128, which gives an offset of 128.
- R5: For c = 0 both channels of the pair open at tick 0, in the same cycle.
- R6: The frame tick is the rising edge at which `frameStrobe` and `dclkEn` are both sampled high; it is tick 0. Later ticks are the edges at which `dclkEn` is sampled high. A channel that opens at tick d drives `accStart` high for exactly one cycle, starting at the clock edge that follows tick d.
- R7: A channel that opens at tick d drives `dataReady` high for exactly one cycle, starting at the clock edge that follows tick d + `FRAME_TICKS`. The two data-ready pulses of a pair are therefore c ticks apart.
- R8: `phaseCode` is sampled only at a frame tick. Changing it between frame ticks does not move any pulse of the frame in progress.
- R9: `frameStrobe` sampled high while `dclkEn` is low starts no frame and produces no pulse.
- R10: No pulse appears other than those of R3 to R7. When the offset drops from one frame to the next, so that two data-ready windows of a channel are pending together, both pulses are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dclkEn | input | 1 | Decimation-clock tick enable, one cycle per tick |
| frameStrobe | input | 1 | Frame start, acted on only together with `dclkEn` |
| phaseCode | input | 24 | Three signed per-pair offset bytes (R2) |
| accStart | output | 6 | Per-channel accumulation-start pulse |
| dataReady | output | 6 | Per-channel data-ready pulse |

## Verification
The bench targets the code -128. A design that negates it into seven bits would fire the odd channel at tick 0 instead of tick 128. It also drops a pair's offset from 127 to 0 between frames: a design with a single data-ready timer per channel would lose the older pulse or emit it a frame late. It rewrites `phaseCode` in mid-frame, which exposes any design that decodes offsets continuously; such a design would shift the pending even-channel starts. Finally, it asserts reset just before pending pulses are due and sends frame strobes while `dclkEn` is low; a design that fails to clear its timers, or that ignores the tick qualifier, would emit stray pulses.

// File: rtl/phx_pkg.sv
`timescale 1ns/1ps
package phx_pkg;

  // Strobes handed from the control unit to the channel timers.
  typedef struct packed {
    logic tick;   // one decimation tick has elapsed
    logic frame;  // this tick is a frame tick: load new offsets
  } phx_strobe_t;

endpackage

// File: rtl/phx_ctrl.sv
`timescale 1ns/1ps
// Control: registers the tick/frame strobes, captures the signed offset
// word at a frame tick and turns each signed byte into two non-negative
// per-channel offsets.
module phx_ctrl
  import phx_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int CODE_W    = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   dclkEn,
  input  logic                                   frameStrobe,
  input  logic [NUM_PAIRS*CODE_W-1:0]            phaseCode,
  output phx_strobe_t                            strb,
  output logic [2*NUM_PAIRS-1:0][CODE_W-1:0]     chanOffset
);

  localparam int REG_W = NUM_PAIRS * CODE_W;

  logic [REG_W-1:0] activeCode;
  logic             frameTick;

  assign frameTick = dclkEn & frameStrobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb       <= '0;
      activeCode <= '0;
    end else begin
      strb.tick  <= dclkEn;
      strb.frame <= frameTick;
      if (frameTick) begin
        activeCode <= phaseCode;
      end
    end
  end

  // Sign selects which channel of the pair is held back by the magnitude.
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [CODE_W-1:0] pairCode;
    logic [CODE_W-1:0] pairMag;
    logic              pairNeg;

    assign pairCode = activeCode[p*CODE_W +: CODE_W];
    assign pairNeg  = pairCode[CODE_W-1];
    // -2^(CODE_W-1) maps to 2^(CODE_W-1), which still fits unsigned.
    assign pairMag  = pairNeg ? (~pairCode + CODE_W'(1)) : pairCode;

    assign chanOffset[2*p]   = pairNeg ? '0 : pairMag;  // even channel lags
    assign chanOffset[2*p+1] = pairNeg ? pairMag : '0;  // reference held back
  end

endmodule

// File: rtl/phx_chan_timer.sv
`timescale 1ns/1ps
// Tick-driven one-shot: loaded on a tick with a count d, it fires on the
// d-th following tick (d = 0 fires on the load tick itself).
module phx_chan_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         fireNow,
  output logic         fire
);

  logic         armed;
  logic [W-1:0] cnt;

  always_comb begin
    if (!tick) begin
      fireNow = 1'b0;
    end else if (load) begin
      fireNow = (loadVal == '0);
    end else begin
      fireNow = armed && (cnt == W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      fire  <= 1'b0;
    end else begin
      fire <= fireNow;
      if (tick) begin
        if (load) begin
          armed <= (loadVal != '0);
          cnt   <= loadVal;
        end else if (armed) begin
          cnt <= cnt - W'(1);
          if (cnt == W'(1)) begin
            armed <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/phx_datapath.sv
`timescale 1ns/1ps
// Datapath: per channel one start timer plus two alternating ready
// timers, so two frames' data-ready windows may overlap.
module phx_datapath
  import phx_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int OFF_W       = 8,
  parameter int FRAME_TICKS = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  phx_strobe_t                   strb,
  input  logic [NUM_CH-1:0][OFF_W-1:0]  chanOffset,
  output logic [NUM_CH-1:0]             accStart,
  output logic [NUM_CH-1:0]             dataReady
);

  localparam int                 FRAME_W   = $clog2(FRAME_TICKS + 1);
  localparam logic [FRAME_W-1:0] FRAME_VAL = FRAME_W'(FRAME_TICKS);
  localparam int                 SLOTS     = 2;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic             startFireNow;
    logic             readyPtr;
    logic [SLOTS-1:0] readyFire;

    phx_chan_timer #(.W(OFF_W)) start_tmr_i (
      .clk     (clk),
      .rst     (rst),
      .tick    (strb.tick),
      .load    (strb.frame),
      .loadVal (chanOffset[ch]),
      .fireNow (startFireNow),
      .fire    (accStart[ch])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        readyPtr <= 1'b0;
      end else if (startFireNow) begin
        readyPtr <= ~readyPtr;
      end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic slotFireNow;

      phx_chan_timer #(.W(FRAME_W)) ready_tmr_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (strb.tick),
        .load    (startFireNow && (readyPtr == 1'(s))),
        .loadVal (FRAME_VAL),
        .fireNow (slotFireNow),
        .fire    (readyFire[s])
      );
    end

    assign dataReady[ch] = |readyFire;
  end

endmodule

// File: rtl/phx_phase_delay_gen.sv
`timescale 1ns/1ps
module phx_phase_delay_gen
  import phx_pkg::*;
#(
  parameter int NUM_PAIRS   = 3,
  parameter int CODE_W      = 8,
  parameter int FRAME_TICKS = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          dclkEn,
  input  logic                          frameStrobe,
  input  logic [NUM_PAIRS*CODE_W-1:0]   phaseCode,
  output logic [2*NUM_PAIRS-1:0]        accStart,
  output logic [2*NUM_PAIRS-1:0]        dataReady
);

  localparam int NUM_CH = 2 * NUM_PAIRS;

  phx_strobe_t                       strb;
  logic [NUM_CH-1:0][CODE_W-1:0]     chanOffset;

  phx_ctrl #(
    .NUM_PAIRS (NUM_PAIRS),
    .CODE_W    (CODE_W)
  ) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .dclkEn      (dclkEn),
    .frameStrobe (frameStrobe),
    .phaseCode   (phaseCode),
    .strb        (strb),
    .chanOffset  (chanOffset)
  );

  phx_datapath #(
    .NUM_CH      (NUM_CH),
    .OFF_W       (CODE_W),
    .FRAME_TICKS (FRAME_TICKS)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .chanOffset (chanOffset),
    .accStart   (accStart),
    .dataReady  (dataReady)
  );

endmodule

// File: rtl/phx_phase_delay_gen_chk.sv
`timescale 1ns/1ps
module phx_phase_delay_gen_chk #(
  parameter int NUM_PAIRS = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   dclkEn,
  input logic                   frameStrobe,
  input logic [2*NUM_PAIRS-1:0] accStart,
  input logic [2*NUM_PAIRS-1:0] dataReady
);

  logic prevRst = 1'b0;

  always_ff @(posedge clk) begin
    prevRst <= rst;
  end

  // R1: one cycle into reset every output is quiet.
  always @(posedge clk) begin
    if (prevRst) begin
      a_r1_quiet_in_reset: assert (accStart == '0 && dataReady == '0)
        else $error("accStart/dataReady active during reset");
    end
  end

  // R6: a start pulse only follows a decimation tick (two-stage path).
  a_r6_start_after_tick: assert property (@(posedge clk) disable iff (rst)
    (|accStart) |-> $past(dclkEn, 2))
    else $error("accStart without a preceding tick");

  // R6: every start pulse lasts one cycle.
  a_r6_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (|accStart) |=> ((accStart & $past(accStart)) == '0))
    else $error("accStart held longer than one cycle");

  // R7: every data-ready pulse lasts one cycle.
  a_r7_ready_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (|dataReady) |=> ((dataReady & $past(dataReady)) == '0))
    else $error("dataReady held longer than one cycle");

  // R3 / R4 / R5: in every pair one channel opens right at the frame tick.
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_anchor
    a_r3_pair_anchor: assert property (@(posedge clk) disable iff (rst)
      (dclkEn && frameStrobe) |=> ##1 (accStart[2*p] || accStart[2*p+1]))
      else $error("pair %0d has no channel opening at the frame tick", p);
  end

endmodule

bind phx_phase_delay_gen phx_phase_delay_gen_chk #(
  .NUM_PAIRS (NUM_PAIRS)
) chk_i (.*);

// File: tb/phx_phase_delay_gen_tb_top.sv
`timescale 1ns/1ps
module phx_phase_delay_gen_tb_top;

  localparam int NUM_PAIRS   = 3;
  localparam int CODE_W      = 8;
  localparam int FRAME_TICKS = 256;
  localparam int NUM_CH      = 2 * NUM_PAIRS;
  localparam int REG_W       = NUM_PAIRS * CODE_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              dclkEn = 1'b0;
  logic              frameStrobe = 1'b0;
  logic [REG_W-1:0]  phaseCode = '0;
  logic [NUM_CH-1:0] accStart;
  logic [NUM_CH-1:0] dataReady;

  phx_phase_delay_gen #(
    .NUM_PAIRS   (NUM_PAIRS),
    .CODE_W      (CODE_W),
    .FRAME_TICKS (FRAME_TICKS)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .dclkEn      (dclkEn),
    .frameStrobe (frameStrobe),
    .phaseCode   (phaseCode),
    .accStart    (accStart),
    .dataReady   (dataReady)
  );

  always #2 clk = ~clk;  // 250 MHz

  int    nChecks = 0;
  int    nFail   = 0;
  bit    done    = 1'b0;
  string quietTag = "R10";

  // Bench-side tick bookkeeping: outputs seen after edge k belong to the
  // tick sampled at edge k-1 (strobe register, then timer register).
  longint tickIdx = 0;
  logic   pTick0 = 1'b0, pTick1 = 1'b0;
  longint pIdx0 = 0, pIdx1 = 0;

  always @(posedge clk) begin
    pTick0 <= dclkEn && !rst;
    pIdx0  <= tickIdx;
    pTick1 <= pTick0 && !rst;
    pIdx1  <= pIdx0;
    if (dclkEn && !rst) tickIdx <= tickIdx + 1;
  end

  typedef struct {
    longint due;
    int     bitIdx;   // 0..5 accStart, 6..11 dataReady
    string  req;
  } item_t;
  item_t sbQ[$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops every item due at the tick just resolved (R6, R7 exact
  // cycle) and flags any pulse nobody expected (R10 or the current tag).
  logic [2*NUM_CH-1:0] monExp, monAct;
  string               monTag;
  always @(negedge clk) begin
    monExp = '0;
    monTag = quietTag;
    if (pTick1) begin
      for (int i = sbQ.size() - 1; i >= 0; i--) begin
        if (sbQ[i].due == pIdx1) begin
          monExp[sbQ[i].bitIdx] = 1'b1;
          monTag = sbQ[i].req;
          sbQ.delete(i);
        end
      end
    end
    monAct = {dataReady, accStart};
    if (monExp != '0 || monAct != '0) begin
      check(monAct == monExp, monTag, $sformatf("pulses tick %0d", pIdx1),
            longint'(monAct), longint'(monExp));
    end
  end

  // Driver: expected pulses for a frame starting at tick t0 (R2 field map).
  task automatic pushFrame(logic [REG_W-1:0] code, longint t0, string tagOvr);
    for (int p = 0; p < NUM_PAIRS; p++) begin
      int    c;
      int    evOff, odOff;
      string tg;
      c     = int'($signed(code[p*CODE_W +: CODE_W]));
      evOff = (c > 0) ? c : 0;
      odOff = (c < 0) ? -c : 0;
      if (tagOvr != "")  tg = tagOvr;
      else if (c > 0)    tg = "R3";
      else if (c < 0)    tg = "R4";
      else               tg = "R5";
      sbQ.push_back('{t0 + evOff, 2*p, tg});
      sbQ.push_back('{t0 + odOff, 2*p + 1, tg});
      sbQ.push_back('{t0 + evOff + FRAME_TICKS, NUM_CH + 2*p, "R7"});
      sbQ.push_back('{t0 + odOff + FRAME_TICKS, NUM_CH + 2*p + 1, "R7"});
    end
  endtask

  task automatic tickCycle(bit fs);
    @(posedge clk); #1;
    dclkEn = 1'b1; frameStrobe = fs;
    @(posedge clk); #1;
    dclkEn = 1'b0; frameStrobe = 1'b0;
  endtask

  task automatic runTicks(int n);
    repeat (n) tickCycle(1'b0);
  endtask

  task automatic issueFrame(logic [REG_W-1:0] code, string tagOvr);
    @(posedge clk); #1;
    phaseCode = code; dclkEn = 1'b1; frameStrobe = 1'b1;
    pushFrame(code, tickIdx, tagOvr);
    @(posedge clk); #1;
    dclkEn = 1'b0; frameStrobe = 1'b0;
  endtask

  task automatic quietCheck(string req);
    @(negedge clk);
    check(accStart == '0 && dataReady == '0, req, "outputs quiet",
          longint'({dataReady, accStart}), 0);
  endtask

  initial begin
    // R1: reset state, frame strobes during reset ignored.
    quietTag = "R1";
    repeat (3) begin
      tickCycle(1'b1);
      quietCheck("R1");
    end
    @(posedge clk); #1 rst = 1'b0;
    quietTag = "R10";

    // R5: all codes zero.
    issueFrame(24'h000000, "");
    runTicks(FRAME_TICKS - 1);
    // R2/R3/R4: A=+5, B=-3, C=+127.
    issueFrame(24'h7FFD05, "");
    runTicks(FRAME_TICKS - 1);
    // R4 with -128 on A, B=+1, C=-1.
    issueFrame(24'hFF0180, "");
    runTicks(FRAME_TICKS - 1);
    // A=+64, B=-128, C=0.
    issueFrame(24'h008040, "");
    runTicks(FRAME_TICKS - 1);

    // R8: code rewritten mid-frame must not move this frame's pulses.
    issueFrame(24'h010203, "R8");
    runTicks(10);
    phaseCode = 24'h7F7F7F;
    runTicks(FRAME_TICKS - 11);

    // R10: offset falls from 127 to 0, two ready windows in flight.
    issueFrame(24'h7F7F7F, "");
    runTicks(FRAME_TICKS - 1);
    issueFrame(24'h000000, "");
    runTicks(2);

    // R9: strobe while dclkEn is low starts nothing.
    quietTag = "R9";
    @(posedge clk); #1 frameStrobe = 1'b1;
    @(posedge clk); #1 frameStrobe = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(accStart == '0, "R9", "accStart after stray strobe",
            longint'(accStart), 0);
    end
    runTicks(3);
    quietTag = "R10";
    runTicks(FRAME_TICKS - 6);

    // R1: reset in mid-frame clears pending offsets.
    issueFrame(24'h050505, "");
    runTicks(3);
    @(posedge clk); #1 rst = 1'b1;
    sbQ.delete();
    quietTag = "R1";
    repeat (4) begin
      tickCycle(1'b1);
      quietCheck("R1");
    end
    @(posedge clk); #1 rst = 1'b0;
    repeat (8) begin
      tickCycle(1'b0);
      quietCheck("R1");
    end
    runTicks(FRAME_TICKS + 20);
    quietTag = "R10";

    // Fresh frame after reset: A=+127, B=-1, C=-127.
    issueFrame(24'h81FF7F, "");
    runTicks(FRAME_TICKS + 140);

    // R10: every expected pulse was delivered.
    check(sbQ.size() == 0, "R10", "undelivered pulses",
          longint'(sbQ.size()), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule